// File: doc/BRIEF.md
# Terminal Master-Reset and Initialization Sequencer

This block sequences the bring-up of a bus terminal after a master reset. A low-to-high edge on the master reset pin aborts whatever the terminal was doing. A registered clear strobe tells the protocol engine, the encoder/decoder and the time-tag counter to drop their state. After a fixed delay of about 200 ns, the block captures the configuration straps into an operational status register. It then optionally runs a pattern test over the whole external RAM and zeroes every RAM word from a base address upward. Finally it raises READY so the host can program its tables.

Terminal execution begins only when the host writes the start bit of the configuration register while READY is high. A software-reset bit in the same register stops execution without disturbing what the host has already set up. When the auto-initialization strap is set, the block does not raise READY. It raises a request flag instead, and the serial loader that handles that case lies outside this block.

Top module: `term_init_seq`

## Requirements
- R1: One cycle after the clock edge that first sees `mr_pin` high after a low, `ready`, `active` and `irq_out` are low, `core_clear` is high, and the status, configuration and built-in-test registers read as zero.
- R2: `core_clear` stays high for exactly LATCH_CYC = ceil(LATCH_NS*CLK_MHZ/1000) cycles after that edge, which is 40 cycles by default.
- R3: The straps are sampled on the LATCH_CYC-th edge after the master-reset edge into the status register. Its layout is bits 4:0 address, bit 5 address parity, bit 6 auto-init, bit 7 lock, bit 8 interrupt select, and bits 15:9 zero.
- R4: A read returns data one cycle after `host_rd`. While `ready` is low, every read returns the status register whatever the address. Once `ready` is high, address 0x00 returns the status register, 0x01 the configuration register, 0x14 the built-in-test word, and any other address returns zero.
- R5: With `strap_mtoff` low, every RAM address is written with PATTERN (default 0xA5A5) and read back, then written with its complement and read back. Any mismatch sets bit 3 of the built-in-test word.
- R6: With `strap_mtoff` high, the test is skipped: RAM below CLR_BASE keeps its contents and the built-in-test word stays zero.
- R7: In both cases, every RAM address from CLR_BASE (default 0x20) to the top is written with zero before the sequence ends.
- R8: With the latched auto-init bit low, `ready` rises when the sequence ends. With it high, `auto_req` rises and `ready` stays low.
- R9: Host writes while `ready` is low have no effect. The configuration register still reads zero afterwards, and `active` stays low.
- R10: A write to address 0x01 with bit 15 (start) set while `ready` is high makes `active` high on the next cycle.
- R11: A write to address 0x01 with bit 14 (software reset) set while `ready` is high does four things. It drops `active` on the next cycle and pulses `core_clear` for one cycle. It clears the start bit and leaves `ready`, the other configuration bits and the built-in-test word unchanged. The other data bits of that write are discarded.
- R12: `irq_out` is `irq_evt` registered, gated by `active`. It is low whenever `active` was low in the previous cycle.
- R13: After the synchronous reset `rst`, all outputs are low and the block waits for a master-reset edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mr_pin | input | 1 | Master reset pin; its rising edge starts the sequence |
| strap_addr | input | 5 | Terminal address straps |
| strap_par | input | 1 | Address parity strap |
| strap_auto | input | 1 | Auto-initialization select strap |
| strap_lock | input | 1 | Lock strap |
| strap_isel | input | 1 | Interrupt select strap |
| strap_mtoff | input | 1 | High skips the RAM test |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | RAM_AW | RAM address |
| ram_wdata | output | DATA_W | RAM write data |
| ram_rdata | input | DATA_W | RAM read data, one cycle after the address |
| host_wr | input | 1 | Host register write strobe |
| host_rd | input | 1 | Host register read strobe |
| host_addr | input | HA_W | Host register address |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Host read data, valid one cycle after `host_rd` |
| irq_evt | input | 1 | Interrupt event from the terminal core |
| ready | output | 1 | Initialization done, host may configure |
| auto_req | output | 1 | Auto-initialization branch selected |
| active | output | 1 | Terminal execution enabled |
| irq_out | output | 1 | Interrupt output |
| core_clear | output | 1 | Clear strobe for engine, codec and time-tag |

## Verification
Several relations are checked on every cycle. The outputs must collapse after a master-reset edge. The clear strobe may never outlast the latch window. READY may only drop because of such an edge, and it never coexists with the auto-init request. ACTIVE may only rise out of READY, and an interrupt needs ACTIVE and an event in the cycle before. Only the bench scenarios can show the rest, because they need a RAM model and knowledge of the data. That covers the exact cycle on which the straps are captured, the read-before-READY override, the pass/fail outcome of the RAM test with an injected stuck bit, what the RAM holds after the test and the clear, and what the configuration register retains across a software reset.

// File: rtl/tis_pkg.sv
package tis_pkg;
  typedef enum logic [2:0] {
    ST_UNINIT, ST_LATCH, ST_MEM, ST_AUTO, ST_READY
  } seq_t;

  typedef enum logic [2:0] {
    PH_IDLE, PH_W0, PH_R0, PH_W1, PH_R1, PH_CLR
  } ph_t;

  localparam int STRAP_W   = 9;
  localparam int ADR_OPST  = 'h00;
  localparam int ADR_CFG   = 'h01;
  localparam int ADR_BITW  = 'h14;
  localparam int CFG_START = 15;
  localparam int CFG_SRST  = 14;
  localparam int BITW_MTF  = 3;
  localparam int OPST_AUTO = 6;
endpackage

// File: rtl/tis_delay.sv
module tis_delay #(
  parameter int CYC = 40
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic expired
);
  localparam int CW = $clog2(CYC + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (load)       cnt <= CW'(CYC - 1);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/tis_ramtest.sv
module tis_ramtest
  import tis_pkg::*;
#(
  parameter int          AW       = 8,
  parameter int          DW       = 16,
  parameter int          CLR_BASE = 32,
  parameter logic [15:0] PATTERN  = 16'hA5A5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          abort,
  input  logic          go,
  input  logic          skip,
  output logic          ram_we,
  output logic [AW-1:0] ram_addr,
  output logic [DW-1:0] ram_wdata,
  input  logic [DW-1:0] ram_rdata,
  output logic          done,
  output logic          mismatch
);
  localparam logic [AW-1:0] LAST  = '1;
  localparam logic [AW-1:0] FIRST = AW'(CLR_BASE);
  localparam logic [DW-1:0] PAT   = DW'(PATTERN);

  ph_t           ph;
  logic [AW-1:0] cnt;
  logic          rd_q, chk_v;
  logic [DW-1:0] exp_q, chk_exp;

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      ph <= PH_IDLE; cnt <= '0; ram_we <= 1'b0; ram_addr <= '0;
      ram_wdata <= '0; rd_q <= 1'b0; exp_q <= '0; chk_v <= 1'b0;
      chk_exp <= '0; done <= 1'b0;
    end else begin
      done    <= 1'b0;
      ram_we  <= 1'b0;
      rd_q    <= 1'b0;
      chk_v   <= rd_q;
      chk_exp <= exp_q;
      if (ph != PH_IDLE) ram_addr <= cnt;
      case (ph)
        PH_IDLE: if (go) begin
          ph  <= skip ? PH_CLR : PH_W0;
          cnt <= skip ? FIRST : '0;
        end
        PH_W0: begin ram_we <= 1'b1; ram_wdata <= PAT; end
        PH_R0: begin rd_q <= 1'b1; exp_q <= PAT; end
        PH_W1: begin ram_we <= 1'b1; ram_wdata <= ~PAT; end
        PH_R1: begin rd_q <= 1'b1; exp_q <= ~PAT; end
        PH_CLR: begin ram_we <= 1'b1; ram_wdata <= '0; end
        default: ph <= PH_IDLE;
      endcase
      if (ph != PH_IDLE) begin
        if (cnt == LAST) begin
          case (ph)
            PH_W0:   begin ph <= PH_R0;  cnt <= '0;    end
            PH_R0:   begin ph <= PH_W1;  cnt <= '0;    end
            PH_W1:   begin ph <= PH_R1;  cnt <= '0;    end
            PH_R1:   begin ph <= PH_CLR; cnt <= FIRST; end
            default: begin ph <= PH_IDLE; cnt <= '0; done <= 1'b1; end
          endcase
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assign mismatch = chk_v && (ram_rdata != chk_exp);
endmodule

// File: rtl/tis_regs.sv
module tis_regs
  import tis_pkg::*;
#(
  parameter int HA_W = 8,
  parameter int DW   = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic               latch_en,
  input  logic [STRAP_W-1:0] straps,
  input  logic               fail_set,
  input  logic               ready,
  input  logic               host_wr,
  input  logic               host_rd,
  input  logic [HA_W-1:0]    host_addr,
  input  logic [DW-1:0]      host_wdata,
  output logic [DW-1:0]      host_rdata,
  output logic               start_req,
  output logic               srst_req,
  output logic               auto_bit
);
  logic [DW-1:0] opst, cfg, bitw, dec;
  logic          wr_cfg;

  assign wr_cfg    = host_wr && ready && (host_addr == HA_W'(ADR_CFG));
  assign srst_req  = wr_cfg && host_wdata[CFG_SRST];
  assign start_req = wr_cfg && host_wdata[CFG_START] && !host_wdata[CFG_SRST];
  assign auto_bit  = opst[OPST_AUTO];

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      opst <= '0; cfg <= '0; bitw <= '0;
    end else begin
      if (latch_en) opst <= {{(DW-STRAP_W){1'b0}}, straps};
      if (fail_set) bitw[BITW_MTF] <= 1'b1;
      if (srst_req)    cfg[CFG_START] <= 1'b0;
      else if (wr_cfg) cfg <= host_wdata & ~(DW'(1) << CFG_SRST);
    end
  end

  always_comb begin
    case (host_addr)
      HA_W'(ADR_OPST): dec = opst;
      HA_W'(ADR_CFG):  dec = cfg;
      HA_W'(ADR_BITW): dec = bitw;
      default:         dec = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)          host_rdata <= '0;
    else if (host_rd) host_rdata <= ready ? dec : opst;
  end
endmodule

// File: rtl/term_init_seq.sv
module term_init_seq
  import tis_pkg::*;
#(
  parameter int          CLK_MHZ  = 200,
  parameter int          LATCH_NS = 200,
  parameter int          RAM_AW   = 8,
  parameter int          DATA_W   = 16,
  parameter int          HA_W     = 8,
  parameter int          CLR_BASE = 32,
  parameter logic [15:0] PATTERN  = 16'hA5A5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mr_pin,
  input  logic [4:0]        strap_addr,
  input  logic              strap_par,
  input  logic              strap_auto,
  input  logic              strap_lock,
  input  logic              strap_isel,
  input  logic              strap_mtoff,
  output logic              ram_we,
  output logic [RAM_AW-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_wdata,
  input  logic [DATA_W-1:0] ram_rdata,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [HA_W-1:0]   host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              irq_evt,
  output logic              ready,
  output logic              auto_req,
  output logic              active,
  output logic              irq_out,
  output logic              core_clear
);
  localparam int LATCH_CYC_RAW = (LATCH_NS * CLK_MHZ + 999) / 1000;
  localparam int LATCH_CYC     = (LATCH_CYC_RAW < 1) ? 1 : LATCH_CYC_RAW;

  seq_t st, nxt;
  logic mr_q, rise, expired, leave_latch, mem_done, mismatch;
  logic start_req, srst_req, auto_bit;
  logic [STRAP_W-1:0] straps;

  assign rise        = mr_pin && !mr_q;
  assign leave_latch = (st == ST_LATCH) && expired && !rise;
  assign straps      = {strap_isel, strap_lock, strap_auto, strap_par, strap_addr};

  always_comb begin
    nxt = st;
    if (rise) nxt = ST_LATCH;
    else begin
      case (st)
        ST_LATCH: if (expired)  nxt = ST_MEM;
        ST_MEM:   if (mem_done) nxt = auto_bit ? ST_AUTO : ST_READY;
        default:  nxt = st;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_UNINIT; mr_q <= 1'b1; ready <= 1'b0; auto_req <= 1'b0;
      active <= 1'b0; irq_out <= 1'b0; core_clear <= 1'b0;
    end else begin
      st         <= nxt;
      mr_q       <= mr_pin;
      ready      <= (nxt == ST_READY);
      auto_req   <= (nxt == ST_AUTO);
      core_clear <= (nxt == ST_LATCH) || srst_req;
      if (rise || srst_req) active <= 1'b0;
      else if (start_req)   active <= 1'b1;
      irq_out    <= !rise && !srst_req && active && irq_evt;
    end
  end

  tis_delay #(.CYC(LATCH_CYC)) u_dly (
    .clk(clk), .rst(rst), .load(rise), .expired(expired)
  );

  tis_ramtest #(.AW(RAM_AW), .DW(DATA_W), .CLR_BASE(CLR_BASE), .PATTERN(PATTERN)) u_mem (
    .clk(clk), .rst(rst), .abort(rise), .go(leave_latch), .skip(strap_mtoff),
    .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .ram_rdata(ram_rdata), .done(mem_done), .mismatch(mismatch)
  );

  tis_regs #(.HA_W(HA_W), .DW(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .clr(rise), .latch_en(leave_latch), .straps(straps),
    .fail_set(mismatch), .ready(ready), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .start_req(start_req), .srst_req(srst_req), .auto_bit(auto_bit)
  );
endmodule

// File: rtl/tis_checker.sv
module tis_checker #(
  parameter int CLK_MHZ  = 200,
  parameter int LATCH_NS = 200
) (
  input logic clk,
  input logic rst,
  input logic mr_pin,
  input logic ready,
  input logic auto_req,
  input logic active,
  input logic irq_out,
  input logic irq_evt,
  input logic core_clear
);
  localparam int LC_RAW = (LATCH_NS * CLK_MHZ + 999) / 1000;
  localparam int LC     = (LC_RAW < 1) ? 1 : LC_RAW;

  logic        mr_d;
  logic [31:0] clr_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      mr_d <= 1'b1; clr_run <= '0;
    end else begin
      mr_d    <= mr_pin;
      clr_run <= core_clear ? clr_run + 1 : '0;
    end
  end

  a_r1_edge_collapse: assert property (@(posedge clk) disable iff (rst)
    (mr_pin && !mr_d) |=> (!ready && !active && !irq_out && core_clear));

  a_r1_ready_drop_cause: assert property (@(posedge clk) disable iff (rst)
    $fell(ready) |-> $past(mr_pin && !mr_d));

  a_r2_clear_bound: assert property (@(posedge clk) disable iff (rst)
    core_clear |-> (clr_run < LC));

  a_r8_ready_auto_excl: assert property (@(posedge clk) disable iff (rst)
    !(ready && auto_req));

  a_r10_active_from_ready: assert property (@(posedge clk) disable iff (rst)
    $rose(active) |-> $past(ready));

  a_r12_irq_gated: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> $past(active && irq_evt));
endmodule

bind term_init_seq tis_checker #(.CLK_MHZ(CLK_MHZ), .LATCH_NS(LATCH_NS)) u_chk (
  .clk(clk), .rst(rst), .mr_pin(mr_pin), .ready(ready), .auto_req(auto_req),
  .active(active), .irq_out(irq_out), .irq_evt(irq_evt), .core_clear(core_clear)
);

// File: tb/term_init_seq_test.sv
module term_init_seq_test;
  localparam int AW  = 8;
  localparam int DW  = 16;
  localparam int HAW = 8;
  localparam int LCYC = 40;
  localparam logic [15:0] PAT = 16'hA5A5;

  logic clk = 1'b0, rst = 1'b1, mr_pin = 1'b0;
  logic [4:0] strap_addr = '0;
  logic strap_par = 0, strap_auto = 0, strap_lock = 0, strap_isel = 0, strap_mtoff = 0;
  logic ram_we;
  logic [AW-1:0] ram_addr;
  logic [DW-1:0] ram_wdata, ram_rdata;
  logic host_wr = 0, host_rd = 0;
  logic [HAW-1:0] host_addr = '0;
  logic [DW-1:0] host_wdata = '0, host_rdata;
  logic irq_evt = 0;
  logic ready, auto_req, active, irq_out, core_clear;

  int n_chk = 0, n_fail = 0;
  logic fault = 0, pre_en = 0;
  logic [DW-1:0] pre_val = '0;
  logic [DW-1:0] mem [0:(1<<AW)-1];
  logic rv = 0;
  logic [DW-1:0] exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  term_init_seq uut (
    .clk(clk), .rst(rst), .mr_pin(mr_pin), .strap_addr(strap_addr), .strap_par(strap_par),
    .strap_auto(strap_auto), .strap_lock(strap_lock), .strap_isel(strap_isel),
    .strap_mtoff(strap_mtoff), .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .ram_rdata(ram_rdata), .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .irq_evt(irq_evt), .ready(ready),
    .auto_req(auto_req), .active(active), .irq_out(irq_out), .core_clear(core_clear)
  );

  // RAM model with one-cycle read and an optional stuck-at-0 on bit 0 of word 0x30
  always @(posedge clk) begin
    if (pre_en) begin
      for (int i = 0; i < (1<<AW); i++) mem[i] <= pre_val;
    end else if (ram_we) begin
      mem[ram_addr] <= (fault && ram_addr == 8'h30) ? (ram_wdata & 16'hFFFE) : ram_wdata;
    end
    ram_rdata <= mem[ram_addr];
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  // scoreboard monitor: compares read data one cycle after each strobe
  always @(posedge clk) rv <= host_rd;
  always @(negedge clk) begin
    if (rv) begin
      if (exp_q.size() == 0) chk("scoreboard", 1, 0);
      else chk(tag_q.pop_front(), host_rdata, exp_q.pop_front());
    end
  end

  task automatic rd(logic [7:0] a, logic [15:0] e, string t);
    @(negedge clk);
    host_rd = 1; host_addr = a; exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    host_rd = 0;
  endtask

  task automatic wr(logic [7:0] a, logic [15:0] d);
    @(negedge clk);
    host_wr = 1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 0;
  endtask

  task automatic mr_edge();
    @(negedge clk); mr_pin = 0;
    @(negedge clk); mr_pin = 1;
  endtask

  task automatic preload(logic [15:0] v);
    @(negedge clk); pre_val = v; pre_en = 1;
    @(negedge clk); pre_en = 0;
  endtask

  task automatic wait_end();
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (ready || auto_req) break;
    end
  endtask

  task automatic mem_scan(logic [15:0] lo, string tlo, string thi);
    int bad_lo = 0, bad_hi = 0;
    for (int i = 0; i < (1<<AW); i++) begin
      if (i < 32 && mem[i] !== lo) bad_lo++;
      if (i >= 32 && mem[i] !== 16'h0) bad_hi++;
    end
    chk(tlo, bad_lo, 0);
    chk(thi, bad_hi, 0);
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    finish_up();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R13 reset outputs", {ready, auto_req, active, irq_out, core_clear}, 5'b0);

    // Run 1: test enabled, straps change around the latch edge
    strap_addr = 5'h15; strap_par = 1; strap_auto = 0; strap_lock = 1; strap_isel = 0;
    strap_mtoff = 0; fault = 0;
    mr_edge();                        // now at N0
    @(negedge clk);                   // N1
    chk("R1 outputs after edge", {ready, active, irq_out, core_clear}, 4'b0001);
    rd(8'h14, 16'h0000, "R1 status cleared / R4 override");   // returns at N3
    repeat (LCYC - 3) @(negedge clk); // N_LCYC
    chk("R2 clear still high", core_clear, 1);
    strap_addr = 5'h0A; strap_par = 0; strap_lock = 0; strap_isel = 1;
    @(negedge clk);                   // N_LCYC+1
    chk("R2 clear ended", core_clear, 0);
    strap_addr = 5'h15; strap_par = 1; strap_lock = 1; strap_isel = 0;
    wr(8'h01, 16'h8000);              // R9 write before READY
    chk("R9 active stays low", active, 0);
    rd(8'h01, 16'h010A, "R3 latch edge / R4 read override");
    wait_end();
    chk("R8 ready raised", {ready, auto_req}, 2'b10);
    rd(8'h14, 16'h0000, "R5 test passes");
    rd(8'h01, 16'h0000, "R9 config untouched");
    rd(8'h00, 16'h010A, "R4 status decode");
    rd(8'h05, 16'h0000, "R4 unmapped address");
    mem_scan(~PAT, "R5 low words hold complement", "R7 upper words cleared");
    irq_evt = 1;
    @(negedge clk);
    chk("R12 irq gated off", irq_out, 0);
    @(negedge clk);
    host_wr = 1; host_addr = 8'h01; host_wdata = 16'h8008;
    chk("R10 active before edge", active, 0);
    @(negedge clk);
    host_wr = 0;
    chk("R10 active next cycle", active, 1);
    @(negedge clk);
    chk("R12 irq follows event", irq_out, 1);
    rd(8'h01, 16'h8008, "R10 config value");
    @(negedge clk);
    host_wr = 1; host_addr = 8'h01; host_wdata = 16'h4000;
    @(negedge clk);
    host_wr = 0;
    chk("R11 soft reset outputs", {ready, active, irq_out, core_clear}, 4'b1001);
    @(negedge clk);
    chk("R11 clear one cycle", core_clear, 0);
    rd(8'h01, 16'h0008, "R11 config retained");
    wr(8'h01, 16'h8000);
    chk("R10 restart", active, 1);

    // Run 2: test skipped, fault present but unused
    irq_evt = 0; strap_mtoff = 1; fault = 1;
    preload(16'h1234);
    mr_edge();
    @(negedge clk);
    chk("R1 outputs drop", {ready, active, irq_out}, 3'b0);
    wait_end();
    chk("R8 ready after skip", ready, 1);
    rd(8'h14, 16'h0000, "R6 no fail when skipped");
    rd(8'h00, 16'h00B5, "R3 strap layout");
    mem_scan(16'h1234, "R6 low words untouched", "R7 upper words cleared");

    // Run 3: test enabled with stuck bit
    strap_mtoff = 0;
    mr_edge();
    wait_end();
    rd(8'h14, 16'h0008, "R5 fail bit");

    // Run 4: auto-init strap
    strap_auto = 1; strap_mtoff = 1; fault = 0;
    mr_edge();
    wait_end();
    @(negedge clk);
    chk("R8 auto branch", {ready, auto_req}, 2'b01);
    rd(8'h14, 16'h00F5, "R4 override while not ready");
    wr(8'h01, 16'h8000);
    @(negedge clk);
    chk("R9 start ignored", active, 0);

    repeat (3) @(negedge clk);
    chk("scoreboard drained", exp_q.size(), 0);
    finish_up();
  end
endmodule